// File: doc/BRIEF.md
# Little-Endian Byte-Addressed Memory Port

This block is the memory slave behind a load/store processor. It takes a single-cycle request carrying a 32-bit byte address, a direction, a size (word or byte) and 32 bits of write data. One clock later it answers with registered read data and two error flags. Inside are two regions, both held as four byte-wide lanes in little-endian order.

The first region is a read-only constant store whose contents are computed at elaboration. The second is a read/write RAM. The block decodes the address into a region and steers store bytes onto lanes. It zero-extends byte loads and rotates word loads made at a halfword offset. Stores aimed at the constant region are dropped without a flag. Misaligned accesses and accesses to unmapped space are refused and flagged.

Each lane is a simple synchronous byte memory, so an FPGA flow can map it onto block RAM. Both regions may be modelled with fewer words than their address span. Addresses inside a span then alias onto the modelled words.

Top module: `mem_port`

## Requirements
- R1: After reset, rsp_valid, align_err and decode_err are low. A request sampled at a rising edge gets its response just after that edge: rsp_valid is high for that one cycle, and low in any cycle that follows an edge without a request. Store responses and error-free store responses carry rsp_rdata = 0.
- R2: A word load whose address ends in 2'b00 returns the four bytes from that address upward, with the byte at the lowest address in bits [7:0].
- R3: A byte load returns the addressed byte in bits [7:0] and zero in bits [31:8].
- R4: A word load whose address ends in 2'b10 reads the aligned word and returns it with its upper and lower 16-bit halves exchanged. For stored bytes 01 02 03 04 the result is 0x02010403.
- R5: An aligned word store writes all four bytes of req_wdata to the aligned word, little-endian.
- R6: A byte store writes req_wdata[7:0] to the single addressed byte and leaves the other three bytes of that word unchanged.
- R7: The constant region's byte at region offset k holds (k + FLASH_FILL) mod 256, where k is taken modulo the modelled size. Word and byte stores to this region change nothing and raise no flag.
- R8: A word load whose address ends in 2'b01 or 2'b11 raises align_err and returns the aligned word without rotation. A word store whose address does not end in 2'b00 raises align_err and writes nothing.
- R9: An access that hits neither region raises decode_err and never align_err. Such a load returns 0 and such a store changes no memory.
- R10: The constant region spans 0x00000000 to 0x0007FFFF and the RAM spans 0x40000000 to 0x4000FFFF. Within a span, the modelled word index is the byte offset divided by 4, modulo the modelled word count. With the defaults, addresses 1 KiB apart alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response for the request of the previous edge |
| rsp_rdata | output | 32 | Load result, 0 for stores and refused loads |
| align_err | output | 1 | Misaligned word access was refused or left unrotated |
| decode_err | output | 1 | Address hit no region |

## Verification
The bench probes the halfword-offset load against the odd offsets. A design that rotated by the wrong amount, or that also rotated odd offsets, would return byte orders that differ from 0x02010403-style swaps. It stores into the constant region and reads back, which catches any path that lets a write reach those lanes. It also follows a byte store with reads of the neighbouring lanes, catching steering that smears the byte across the word. The region boundaries (last word of each span, first address past each span) and aliasing across the modelled depth expose off-by-one decoding. A refused misaligned store followed by a read-back shows whether any lane was still written.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_CONST = 2'd1,
    REG_RAM   = 2'd2
  } region_e;
endpackage

// File: rtl/mp_decode.sv
module mp_decode
  import mp_pkg::*;
#(
  parameter logic [31:0] CONST_BASE = 32'h0000_0000,
  parameter logic [31:0] CONST_SPAN = 32'h0008_0000,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SPAN   = 32'h0001_0000,
  parameter int          CONST_AW   = 8,
  parameter int          RAM_AW     = 8
) (
  input  logic [31:0]         addr,
  output region_e             region,
  output logic [CONST_AW-1:0] const_idx,
  output logic [RAM_AW-1:0]   ram_idx
);
  logic [31:0] const_off;
  logic [31:0] ram_off;

  always_comb begin
    const_off = addr - CONST_BASE;
    ram_off   = addr - RAM_BASE;
    if (addr >= CONST_BASE && const_off < CONST_SPAN)
      region = REG_CONST;
    else if (addr >= RAM_BASE && ram_off < RAM_SPAN)
      region = REG_RAM;
    else
      region = REG_NONE;
    const_idx = const_off[CONST_AW+1:2];
    ram_idx   = ram_off[RAM_AW+1:2];
  end
endmodule

// File: rtl/mp_byte_lane.sv
module mp_byte_lane
  import mp_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AW     = $clog2(DEPTH),
  parameter int LANE   = 0,
  parameter bit IS_ROM = 1'b0,
  parameter int FILL   = 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  logic [LANE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = IS_ROM ? LANE_W'((i * LANES + LANE + FILL) & 255) : '0;
  end

  always_ff @(posedge clk) begin
    if (!IS_ROM && we)
      mem[idx] <= wd;
    rd <= mem[idx];
  end
endmodule

// File: rtl/mp_store_steer.sv
module mp_store_steer
  import mp_pkg::*;
(
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_byte,
  input  logic [1:0]              lane_off,
  input  region_e                 region,
  input  logic [31:0]             wdata,
  output logic [LANES-1:0]        ram_we,
  output logic [LANES*LANE_W-1:0] lane_wd,
  output logic                    misaligned
);
  logic store_ram;

  always_comb begin
    store_ram  = req_valid && req_write && (region == REG_RAM);
    misaligned = !req_byte && (req_write ? (lane_off != 2'b00) : lane_off[0]);
    ram_we     = '0;
    if (store_ram && !misaligned) begin
      if (req_byte) ram_we[lane_off] = 1'b1;
      else          ram_we = '1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_wd
    assign lane_wd[g*LANE_W +: LANE_W] = req_byte ? wdata[LANE_W-1:0]
                                                  : wdata[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/mp_load_fmt.sv
module mp_load_fmt
  import mp_pkg::*;
(
  input  logic        is_byte,
  input  logic [1:0]  lane_off,
  input  logic [31:0] word,
  output logic [31:0] result
);
  always_comb begin
    if (is_byte)
      result = {24'h0, word[lane_off*LANE_W +: LANE_W]};
    else if (lane_off == 2'b10)
      result = {word[15:0], word[31:16]};
    else
      result = word;
  end
endmodule

// File: rtl/mem_port.sv
module mem_port
  import mp_pkg::*;
#(
  parameter logic [31:0] CONST_BASE  = 32'h0000_0000,
  parameter logic [31:0] CONST_SPAN  = 32'h0008_0000,
  parameter logic [31:0] RAM_BASE    = 32'h4000_0000,
  parameter logic [31:0] RAM_SPAN    = 32'h0001_0000,
  parameter int          CONST_WORDS = 256,
  parameter int          RAM_WORDS   = 256,
  parameter int          FLASH_FILL  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_byte,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        align_err,
  output logic        decode_err
);
  localparam int CONST_AW = $clog2(CONST_WORDS);
  localparam int RAM_AW   = $clog2(RAM_WORDS);
  localparam int DATA_W   = LANES * LANE_W;

  region_e             region;
  logic [CONST_AW-1:0] const_idx;
  logic [RAM_AW-1:0]   ram_idx;
  logic [LANES-1:0]    ram_we;
  logic [DATA_W-1:0]   lane_wd;
  logic                misaligned;
  logic [DATA_W-1:0]   const_word;
  logic [DATA_W-1:0]   ram_word;
  logic [DATA_W-1:0]   sel_word;
  logic [31:0]         fmt_word;

  logic    valid_q, write_q, byte_q, align_q, dec_q;
  logic [1:0] off_q;
  region_e region_q;

  mp_decode #(
    .CONST_BASE(CONST_BASE), .CONST_SPAN(CONST_SPAN),
    .RAM_BASE(RAM_BASE), .RAM_SPAN(RAM_SPAN),
    .CONST_AW(CONST_AW), .RAM_AW(RAM_AW)
  ) u_decode (
    .addr(req_addr), .region(region), .const_idx(const_idx), .ram_idx(ram_idx)
  );

  mp_store_steer u_steer (
    .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
    .lane_off(req_addr[1:0]), .region(region), .wdata(req_wdata),
    .ram_we(ram_we), .lane_wd(lane_wd), .misaligned(misaligned)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mp_byte_lane #(
      .DEPTH(CONST_WORDS), .AW(CONST_AW), .LANE(g), .IS_ROM(1'b1), .FILL(FLASH_FILL)
    ) u_const (
      .clk(clk), .we(1'b0), .idx(const_idx),
      .wd(lane_wd[g*LANE_W +: LANE_W]), .rd(const_word[g*LANE_W +: LANE_W])
    );
    mp_byte_lane #(
      .DEPTH(RAM_WORDS), .AW(RAM_AW), .LANE(g), .IS_ROM(1'b0), .FILL(0)
    ) u_ram (
      .clk(clk), .we(ram_we[g]), .idx(ram_idx),
      .wd(lane_wd[g*LANE_W +: LANE_W]), .rd(ram_word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      write_q  <= 1'b0;
      byte_q   <= 1'b0;
      align_q  <= 1'b0;
      dec_q    <= 1'b0;
      off_q    <= 2'b00;
      region_q <= REG_NONE;
    end else begin
      valid_q  <= req_valid;
      write_q  <= req_write;
      byte_q   <= req_byte;
      off_q    <= req_addr[1:0];
      region_q <= region;
      align_q  <= req_valid && (region != REG_NONE) && misaligned;
      dec_q    <= req_valid && (region == REG_NONE);
    end
  end

  always_comb begin
    case (region_q)
      REG_CONST: sel_word = const_word;
      REG_RAM:   sel_word = ram_word;
      default:   sel_word = '0;
    endcase
  end

  mp_load_fmt u_fmt (
    .is_byte(byte_q), .lane_off(off_q), .word(sel_word), .result(fmt_word)
  );

  assign rsp_valid  = valid_q;
  assign align_err  = align_q;
  assign decode_err = dec_q;
  assign rsp_rdata  = (valid_q && !write_q && !dec_q) ? fmt_word : 32'h0;

  // R9: the two error kinds never coexist
  p_err_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(align_err && decode_err));

  // R1: an error flag only appears with a response
  p_err_needs_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    (align_err || decode_err) |-> rsp_valid);

  // R3: byte load upper bits are zero
  p_byte_zext_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_byte) |=> (rsp_rdata[31:8] == 24'h0));

  // R9: unmapped loads read as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && region == REG_NONE) |=> (rsp_rdata == 32'h0));

  // R8: a misaligned word store enables no RAM lane
  p_misaligned_store_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_byte && req_addr[1:0] != 2'b00) |-> (ram_we == '0));

  // R7: a store aimed at the constant region enables no RAM lane
  p_const_store_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr < CONST_SPAN) |-> (ram_we == '0));

  // R6: a byte store enables exactly one lane at most
  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_byte) |-> $onehot0(ram_we));
endmodule

// File: tb/tb_mem_port.sv
module tb_mem_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_byte;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, align_err, decode_err;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] got_data;
  logic        got_valid, got_aerr, got_derr;

  always #4 clk = ~clk;

  mem_port dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .align_err(align_err), .decode_err(decode_err)
  );

  function automatic logic [7:0] cbyte(input logic [31:0] off);
    return 8'(((off % 1024) + 1) & 255);
  endfunction

  function automatic logic [31:0] cword(input logic [31:0] off);
    logic [31:0] b = off & ~32'h3;
    return {cbyte(b + 3), cbyte(b + 2), cbyte(b + 1), cbyte(b)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic by,
                        input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    got_valid = rsp_valid; got_data = rsp_rdata;
    got_aerr  = align_err; got_derr = decode_err;
    req_valid = 1'b0;
  endtask

  task automatic load_expect(input string req, input logic by, input logic [31:0] a,
                             input logic [31:0] exp, input logic aerr, input logic derr);
    access(1'b0, by, a, 32'h0);
    check(req, "rsp_valid", {31'h0, got_valid}, 32'h1);
    check(req, "rdata", got_data, exp);
    check(req, "align_err", {31'h0, got_aerr}, {31'h0, aerr});
    check(req, "decode_err", {31'h0, got_derr}, {31'h0, derr});
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1", "reset errs", {30'h0, align_err, decode_err}, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_timing_r1();
    access(1'b0, 1'b0, 32'h0, 32'h0);
    check("R1", "valid after request", {31'h0, got_valid}, 32'h1);
    @(posedge clk); #1;
    check("R1", "valid drops without request", {31'h0, rsp_valid}, 32'h0);
    access(1'b1, 1'b0, 32'h4000_0100, 32'h5555_AAAA);
    check("R1", "store rdata zero", got_data, 32'h0);
  endtask

  task automatic t_const_reads_r2_r3_r4();
    load_expect("R2", 1'b0, 32'h0, 32'h0403_0201, 1'b0, 1'b0);
    load_expect("R2", 1'b0, 32'h10, cword(32'h10), 1'b0, 1'b0);
    load_expect("R3", 1'b1, 32'h3, 32'h0000_0004, 1'b0, 1'b0);
    load_expect("R4", 1'b0, 32'h2, 32'h0201_0403, 1'b0, 1'b0);
  endtask

  task automatic t_const_protect_r7();
    access(1'b1, 1'b0, 32'h0, 32'hDEAD_BEEF);
    check("R7", "no flag on const store", {30'h0, got_aerr, got_derr}, 32'h0);
    access(1'b1, 1'b1, 32'h1, 32'h0000_00AA);
    load_expect("R7", 1'b0, 32'h0, 32'h0403_0201, 1'b0, 1'b0);
  endtask

  task automatic t_ram_word_r5();
    access(1'b1, 1'b0, 32'h4000_0008, 32'h1122_3344);
    load_expect("R5", 1'b0, 32'h4000_0008, 32'h1122_3344, 1'b0, 1'b0);
    load_expect("R3", 1'b1, 32'h4000_0008, 32'h0000_0044, 1'b0, 1'b0);
    load_expect("R3", 1'b1, 32'h4000_000B, 32'h0000_0011, 1'b0, 1'b0);
  endtask

  task automatic t_ram_byte_r6();
    access(1'b1, 1'b1, 32'h4000_0009, 32'hAABB_CCEE);
    load_expect("R6", 1'b0, 32'h4000_0008, 32'h1122_EE44, 1'b0, 1'b0);
    load_expect("R4", 1'b0, 32'h4000_000A, 32'hEE44_1122, 1'b0, 1'b0);
  endtask

  task automatic t_align_r8();
    load_expect("R8", 1'b0, 32'h4000_0009, 32'h1122_EE44, 1'b1, 1'b0);
    load_expect("R8", 1'b0, 32'h4000_000B, 32'h1122_EE44, 1'b1, 1'b0);
    access(1'b1, 1'b0, 32'h4000_000A, 32'h0);
    check("R8", "misaligned store flag", {31'h0, got_aerr}, 32'h1);
    load_expect("R8", 1'b0, 32'h4000_0008, 32'h1122_EE44, 1'b0, 1'b0);
  endtask

  task automatic t_unmapped_r9();
    load_expect("R9", 1'b0, 32'h2000_0000, 32'h0, 1'b0, 1'b1);
    access(1'b1, 1'b0, 32'h4001_0008, 32'hFFFF_FFFF);
    check("R9", "store decode_err", {30'h0, got_aerr, got_derr}, 32'h1);
    load_expect("R9", 1'b0, 32'h4000_0008, 32'h1122_EE44, 1'b0, 1'b0);
    load_expect("R9", 1'b0, 32'h8000_0001, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_bounds_r10();
    load_expect("R10", 1'b0, 32'h0007_FFFC, 32'h00FF_FEFD, 1'b0, 1'b0);
    load_expect("R10", 1'b0, 32'h0008_0000, 32'h0, 1'b0, 1'b1);
    load_expect("R10", 1'b0, 32'h3FFF_FFFC, 32'h0, 1'b0, 1'b1);
    load_expect("R10", 1'b0, 32'h4000_0408, 32'h1122_EE44, 1'b0, 1'b0);
    access(1'b1, 1'b0, 32'h4000_FFFC, 32'hCAFE_F00D);
    load_expect("R10", 1'b0, 32'h4000_03FC, 32'hCAFE_F00D, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_timing_r1();
    t_const_reads_r2_r3_r4();
    t_const_protect_r7();
    t_ram_word_r5();
    t_ram_byte_r6();
    t_align_r8();
    t_unmapped_r9();
    t_bounds_r10();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule